// File: doc/BRIEF.md
# Two-Channel DMA Transfer Engine

This block moves data on its own between locations in a 20-bit address space that is split into a memory space and an I/O space. It has two independent channels. Each channel holds a source pointer, a destination pointer, a space selection for each pointer, a step mode for each pointer, a transfer width and a 16-bit transfer count. A channel is loaded in one write through a configuration port. It is served whenever it is enabled and its request line is high.

Every transfer is a pair of bus cycles on a simple master interface. The first cycle reads from the source. The second cycle writes the captured data to the destination. Each bus cycle takes at least four clocks, and the engine stretches it while the ready input is low. When both channels request at once, channel 0 wins. A transfer that has started always finishes its write before the other channel gets the bus. After each transfer the pointers step and the count decrements. If terminate-on-count is enabled, a count that reaches zero disables the channel and raises a one-clock done pulse.

Top module: `dma2_engine`

## Requirements
- R1: After a synchronous reset, both strobes are low, `bus_addr` and `bus_wdata` are zero, and every bit of `chan_en` and `done` is zero.
- R2: When the engine is idle and both channels are enabled with their requests high, the next transfer belongs to channel 0.
- R3: A transfer is a read cycle at the channel's source pointer followed directly by a write cycle at its destination pointer. No cycle of the other channel comes between them.
- R4: Each bus cycle lasts four clocks, with the strobe high in the second and third of them. While `bus_ready` is low in the third clock, the cycle stays in that clock with the address and strobe held. `bus_rd` and `bus_wr` are never high together.
- R5: The read data is captured in the last strobe clock of the read cycle, and that value is driven on `bus_wdata` for the whole write cycle.
- R6: The step code is 2 bits: 01 adds, 10 subtracts, and 00 or 11 keeps the pointer. The step size is 1 for a byte transfer (`word`=0) and 2 for a word transfer (`word`=1). Pointers wrap modulo 2^20.
- R7: `bus_io` equals the source space bit (1 = I/O) during the read cycle and the destination space bit during the write cycle.
- R8: The count decrements by one per transfer and wraps from 0 to 0xFFFF. If terminate-on-count is set and the count becomes zero, `chan_en` for that channel falls and its `done` bit is high for exactly one clock. If terminate-on-count is clear, the channel keeps running.
- R9: With parameter `BUS_WIDE`=0, the word setting is ignored: `bus_word` stays low and pointers step by 1.
- R10: A channel that is disabled, or whose request is low, starts no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the channel selected by `cfg_ch` |
| cfg_ch | input | 1 | Channel number for the load |
| cfg_src | input | 20 | Source pointer |
| cfg_dst | input | 20 | Destination pointer |
| cfg_src_io | input | 1 | Source space, 1 = I/O |
| cfg_dst_io | input | 1 | Destination space, 1 = I/O |
| cfg_src_step | input | 2 | Source step code |
| cfg_dst_step | input | 2 | Destination step code |
| cfg_word | input | 1 | 1 = word transfers |
| cfg_count | input | 16 | Transfer count |
| cfg_tc_stop | input | 1 | Stop when the count reaches zero |
| cfg_en | input | 1 | Channel enable |
| dreq | input | 2 | Per-channel transfer request |
| bus_ready | input | 1 | Ready from the addressed target |
| bus_rdata | input | 16 | Read data |
| bus_addr | output | 20 | Bus address |
| bus_io | output | 1 | Bus space, 1 = I/O |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_word | output | 1 | 1 = the current cycle is a word access |
| bus_wdata | output | 16 | Write data |
| chan_en | output | 2 | Enable state of each channel |
| done | output | 2 | One-clock terminal-count pulse per channel |

## Verification
The hardest situation to reach is a request from the other channel that arrives while a transfer is between its read and its write, with `bus_ready` held low. Only in that case could a wrong arbiter split the pair. The bench reaches it in two ways. It raises both requests in the same idle clock. It also keeps channel 1 requesting while channel 0 runs with a random ready pattern. A behavioural reference model is compared with every output on every clock. The ordered queues of captured read and write addresses show priority, stepping, wrap-around and hold.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
    localparam int AW  = 20;
    localparam int DW  = 16;
    localparam int CNW = 16;
    localparam int NCH = 2;
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int PHW = 2;
    localparam logic [PHW-1:0] PH_ADDR = 2'd0;
    localparam logic [PHW-1:0] PH_STB  = 2'd1;
    localparam logic [PHW-1:0] PH_WAIT = 2'd2;
    localparam logic [PHW-1:0] PH_END  = 2'd3;

    typedef enum logic [1:0] {
        STEP_KEEP  = 2'b00,
        STEP_UP    = 2'b01,
        STEP_DOWN  = 2'b10,
        STEP_KEEP2 = 2'b11
    } step_e;

    typedef struct packed {
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic           src_io;
        logic           dst_io;
        step_e          src_step;
        step_e          dst_step;
        logic           word;
        logic [CNW-1:0] count;
        logic           tc_stop;
        logic           en;
    } chan_state_t;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p,
                                               input step_e s,
                                               input logic w);
        logic [AW-1:0] amt;
        amt = w ? AW'(2) : AW'(1);
        case (s)
            STEP_UP:   ptr_next = p + amt;
            STEP_DOWN: ptr_next = p - amt;
            default:   ptr_next = p;
        endcase
    endfunction
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
#(
    parameter bit BUS_WIDE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  chan_state_t cfg_in,
    input  logic        upd,
    output chan_state_t st,
    output logic        done
);
    logic [CNW-1:0] cnt_dec;
    assign cnt_dec = st.count - CNW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cfg_we) begin
                st      <= cfg_in;
                st.word <= cfg_in.word & BUS_WIDE;
            end else if (upd) begin
                st.src   <= ptr_next(st.src, st.src_step, st.word);
                st.dst   <= ptr_next(st.dst, st.dst_step, st.word);
                st.count <= cnt_dec;
                if (st.tc_stop && cnt_dec == '0) begin
                    st.en <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_off_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !st.en);
    p_src_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (upd && !cfg_we && (st.src_step == STEP_KEEP || st.src_step == STEP_KEEP2))
        |=> $stable(st.src));
    p_narrow_r9: assert property (@(posedge clk) disable iff (rst)
        !BUS_WIDE |-> !st.word);
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb
    import dma2_pkg::*;
(
    input  logic [NCH-1:0] req,
    output logic           gnt_valid,
    output logic [CHW-1:0] gnt_idx
);
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_valid = 1'b1;
                gnt_idx   = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
    import dma2_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CHW-1:0] start_ch,
    input  logic           ready,
    input  logic [DW-1:0]  rdata,
    output logic           busy,
    output logic           is_wr,
    output logic [PHW-1:0] phase,
    output logic [CHW-1:0] cur_ch,
    output logic [DW-1:0]  latch,
    output logic           upd
);
    assign upd = busy && is_wr && phase == PH_END;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            is_wr  <= 1'b0;
            phase  <= PH_ADDR;
            cur_ch <= '0;
            latch  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                is_wr  <= 1'b0;
                phase  <= PH_ADDR;
                cur_ch <= start_ch;
            end
        end else if (!(phase == PH_WAIT && !ready)) begin
            if (phase == PH_WAIT && !is_wr)
                latch <= rdata;
            if (phase == PH_END) begin
                phase <= PH_ADDR;
                if (!is_wr) is_wr <= 1'b1;
                else        busy  <= 1'b0;
            end else begin
                phase <= phase + PHW'(1);
            end
        end
    end

    p_stretch_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && phase == PH_WAIT && !ready) |=> (busy && phase == PH_WAIT && $stable(is_wr)));
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && is_wr && $past(busy && is_wr)) |-> $stable(latch));
    p_no_split_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur_ch));
endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
    import dma2_pkg::*;
#(
    parameter bit BUS_WIDE = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic           cfg_ch,
    input  logic [19:0]    cfg_src,
    input  logic [19:0]    cfg_dst,
    input  logic           cfg_src_io,
    input  logic           cfg_dst_io,
    input  logic [1:0]     cfg_src_step,
    input  logic [1:0]     cfg_dst_step,
    input  logic           cfg_word,
    input  logic [15:0]    cfg_count,
    input  logic           cfg_tc_stop,
    input  logic           cfg_en,
    input  logic [1:0]     dreq,
    input  logic           bus_ready,
    input  logic [15:0]    bus_rdata,
    output logic [19:0]    bus_addr,
    output logic           bus_io,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic           bus_word,
    output logic [15:0]    bus_wdata,
    output logic [1:0]     chan_en,
    output logic [1:0]     done
);
    chan_state_t    cfg_in;
    chan_state_t    st [NCH];
    logic [NCH-1:0] req, upd_v;
    logic           gnt_valid, busy, is_wr, upd;
    logic [CHW-1:0] gnt_idx, cur_ch;
    logic [PHW-1:0] phase;
    logic [DW-1:0]  latch;
    chan_state_t    cur;

    always_comb begin
        cfg_in          = '0;
        cfg_in.src      = cfg_src;
        cfg_in.dst      = cfg_dst;
        cfg_in.src_io   = cfg_src_io;
        cfg_in.dst_io   = cfg_dst_io;
        cfg_in.src_step = step_e'(cfg_src_step);
        cfg_in.dst_step = step_e'(cfg_dst_step);
        cfg_in.word     = cfg_word;
        cfg_in.count    = cfg_count;
        cfg_in.tc_stop  = cfg_tc_stop;
        cfg_in.en       = cfg_en;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma2_chan #(.BUS_WIDE(BUS_WIDE)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .cfg_we (cfg_we && cfg_ch == CHW'(i)),
            .cfg_in (cfg_in),
            .upd    (upd_v[i]),
            .st     (st[i]),
            .done   (done[i])
        );
        assign req[i]     = st[i].en && dreq[i];
        assign upd_v[i]   = upd && cur_ch == CHW'(i);
        assign chan_en[i] = st[i].en;
    end

    dma2_arb u_arb (
        .req       (req),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    dma2_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (gnt_valid),
        .start_ch (gnt_idx),
        .ready    (bus_ready),
        .rdata    (bus_rdata),
        .busy     (busy),
        .is_wr    (is_wr),
        .phase    (phase),
        .cur_ch   (cur_ch),
        .latch    (latch),
        .upd      (upd)
    );

    assign cur = st[cur_ch];

    always_comb begin
        bus_addr  = '0;
        bus_io    = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_word  = 1'b0;
        bus_wdata = '0;
        if (busy) begin
            bus_addr = is_wr ? cur.dst : cur.src;
            bus_io   = is_wr ? cur.dst_io : cur.src_io;
            bus_word = cur.word;
            if (phase == PH_STB || phase == PH_WAIT) begin
                bus_rd = !is_wr;
                bus_wr = is_wr;
            end
            if (is_wr) bus_wdata = latch;
        end
    end

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));
    p_prio_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && req[0]) |=> (busy && cur_ch == '0));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && req == '0) |=> !busy);
endmodule

// File: tb/dma2_engine_tb.sv
module dma2_engine_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        cfg_we, cfg_we_n, cfg_ch;
    logic [19:0] cfg_src, cfg_dst;
    logic        cfg_src_io, cfg_dst_io, cfg_word, cfg_tc_stop, cfg_en;
    logic [1:0]  cfg_src_step, cfg_dst_step, dreq, dreq_n;
    logic [15:0] cfg_count;
    logic        rdy_man, rdy_rnd, rnd_mode;
    logic        bus_ready;
    logic [15:0] bus_rdata, bus_wdata, n_rdata, n_wdata;
    logic [19:0] bus_addr, n_addr;
    logic        bus_io, bus_rd, bus_wr, bus_word, n_io, n_rd, n_wr, n_word;
    logic [1:0]  chan_en, done, n_en, n_done;

    function automatic logic [15:0] memval(input logic [19:0] a, input logic io);
        return {a[7:0] ^ 8'hA5 ^ {7'd0, io}, a[15:8] + {4'd0, a[19:16]}};
    endfunction

    assign bus_ready = rnd_mode ? rdy_rnd : rdy_man;
    assign bus_rdata = memval(bus_addr, bus_io);
    assign n_rdata   = memval(n_addr, n_io);

    dma2_engine dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_src_io(cfg_src_io),
        .cfg_dst_io(cfg_dst_io), .cfg_src_step(cfg_src_step),
        .cfg_dst_step(cfg_dst_step), .cfg_word(cfg_word), .cfg_count(cfg_count),
        .cfg_tc_stop(cfg_tc_stop), .cfg_en(cfg_en), .dreq(dreq),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
        .bus_io(bus_io), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .chan_en(chan_en), .done(done));

    dma2_engine #(.BUS_WIDE(1'b0)) dut_n (
        .clk(clk), .rst(rst), .cfg_we(cfg_we_n), .cfg_ch(cfg_ch),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_src_io(cfg_src_io),
        .cfg_dst_io(cfg_dst_io), .cfg_src_step(cfg_src_step),
        .cfg_dst_step(cfg_dst_step), .cfg_word(cfg_word), .cfg_count(cfg_count),
        .cfg_tc_stop(cfg_tc_stop), .cfg_en(cfg_en), .dreq(dreq_n),
        .bus_ready(1'b1), .bus_rdata(n_rdata), .bus_addr(n_addr),
        .bus_io(n_io), .bus_rd(n_rd), .bus_wr(n_wr), .bus_word(n_word),
        .bus_wdata(n_wdata), .chan_en(n_en), .done(n_done));

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_src[2], m_dst[2], m_cnt[2], m_ss[2], m_ds[2];
    bit          m_en[2], m_tc[2], m_word[2], m_sio[2], m_dio[2], m_done[2];
    bit          m_busy, m_wr;
    int          m_clk, m_ch;
    logic [15:0] m_lat;

    function automatic int stepped(input int p, input int code, input bit w);
        int amt = w ? 2 : 1;
        if (code == 1) return (p + amt) & 20'hFFFFF;
        if (code == 2) return (p - amt) & 20'hFFFFF;
        return p;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_wr = 0; m_clk = 0; m_ch = 0; m_lat = '0;
            for (int c = 0; c < 2; c++) begin
                m_en[c] = 0; m_done[c] = 0; m_src[c] = 0; m_dst[c] = 0; m_cnt[c] = 0;
                m_ss[c] = 0; m_ds[c] = 0; m_tc[c] = 0; m_word[c] = 0; m_sio[c] = 0; m_dio[c] = 0;
            end
        end else begin
            m_done[0] = 0; m_done[1] = 0;
            if (!m_busy) begin
                if (m_en[0] && dreq[0])      begin m_busy = 1; m_ch = 0; m_wr = 0; m_clk = 0; end
                else if (m_en[1] && dreq[1]) begin m_busy = 1; m_ch = 1; m_wr = 0; m_clk = 0; end
            end else if (!(m_clk == 2 && !bus_ready)) begin
                if (m_clk == 2 && !m_wr) m_lat = memval(20'(m_src[m_ch]), m_sio[m_ch]);
                if (m_clk < 3) m_clk++;
                else if (!m_wr) begin m_wr = 1; m_clk = 0; end
                else begin
                    m_busy = 0; m_clk = 0;
                    m_src[m_ch] = stepped(m_src[m_ch], m_ss[m_ch], m_word[m_ch]);
                    m_dst[m_ch] = stepped(m_dst[m_ch], m_ds[m_ch], m_word[m_ch]);
                    m_cnt[m_ch] = (m_cnt[m_ch] - 1) & 16'hFFFF;
                    if (m_tc[m_ch] && m_cnt[m_ch] == 0) begin m_en[m_ch] = 0; m_done[m_ch] = 1; end
                end
            end
            if (cfg_we) begin
                m_src[cfg_ch] = cfg_src; m_dst[cfg_ch] = cfg_dst;
                m_sio[cfg_ch] = cfg_src_io; m_dio[cfg_ch] = cfg_dst_io;
                m_ss[cfg_ch] = cfg_src_step; m_ds[cfg_ch] = cfg_dst_step;
                m_word[cfg_ch] = cfg_word; m_cnt[cfg_ch] = cfg_count;
                m_tc[cfg_ch] = cfg_tc_stop; m_en[cfg_ch] = cfg_en; m_done[cfg_ch] = 0;
            end
        end
    end

    // ---------------- per-clock comparison and monitors ----------------
    logic [20:0] rd_q[$], wr_q[$], nrd_q[$];
    int  done_hi[2], rd_len, rd_run, nword_hi;
    bit  prev_rd, prev_wr, prev_nrd, live;

    always @(negedge clk) begin
        if (!rst && live) begin
            logic [19:0] e_addr;
            logic        e_io, e_rd, e_wr, e_word;
            logic [15:0] e_wd;
            e_addr = m_busy ? 20'(m_wr ? m_dst[m_ch] : m_src[m_ch]) : '0;
            e_io   = m_busy && (m_wr ? m_dio[m_ch] : m_sio[m_ch]);
            e_rd   = m_busy && !m_wr && (m_clk == 1 || m_clk == 2);
            e_wr   = m_busy && m_wr && (m_clk == 1 || m_clk == 2);
            e_word = m_busy && m_word[m_ch];
            e_wd   = (m_busy && m_wr) ? m_lat : '0;
            chk(bus_addr == e_addr, "R3/R6", "cycle addr", bus_addr, e_addr);
            chk(bus_io == e_io, "R7", "cycle space", bus_io, e_io);
            chk({bus_rd, bus_wr} == {e_rd, e_wr}, "R4", "cycle strobes", {bus_rd, bus_wr}, {e_rd, e_wr});
            chk(bus_word == e_word, "R6", "cycle width", bus_word, e_word);
            chk(bus_wdata == e_wd, "R5", "cycle wdata", bus_wdata, e_wd);
            chk(chan_en == {m_en[1], m_en[0]}, "R8", "cycle chan_en", chan_en, {m_en[1], m_en[0]});
            chk(done == {m_done[1], m_done[0]}, "R8", "cycle done", done, {m_done[1], m_done[0]});
        end
        if (bus_rd && !prev_rd) rd_q.push_back({bus_io, bus_addr});
        if (bus_wr && !prev_wr) wr_q.push_back({bus_io, bus_addr});
        if (n_rd && !prev_nrd) nrd_q.push_back({n_io, n_addr});
        if (n_word) nword_hi++;
        if (bus_rd) rd_run++;
        else if (prev_rd) begin rd_len = rd_run; rd_run = 0; end
        for (int c = 0; c < 2; c++) if (done[c]) done_hi[c]++;
        prev_rd = bus_rd; prev_wr = bus_wr; prev_nrd = n_rd;
        rdy_rnd <= ($urandom % 4) != 0;
    end

    // ---------------- stimulus ----------------
    int cyc = 0;
    bit timed_out = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !timed_out) begin
            timed_out = 1;
            chk(0, "WDOG", "watchdog expired", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic load(input bit narrow, input bit ch, input logic [19:0] s, input logic [19:0] d,
                        input bit sio, input bit dio, input logic [1:0] ss, input logic [1:0] ds,
                        input bit w, input logic [15:0] cnt, input bit tc, input bit en);
        cfg_ch = ch; cfg_src = s; cfg_dst = d; cfg_src_io = sio; cfg_dst_io = dio;
        cfg_src_step = ss; cfg_dst_step = ds; cfg_word = w; cfg_count = cnt;
        cfg_tc_stop = tc; cfg_en = en;
        if (narrow) cfg_we_n = 1; else cfg_we = 1;
        @(negedge clk);
        cfg_we = 0; cfg_we_n = 0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_off(input int ch);
        for (int i = 0; i < 400 && chan_en[ch]; i++) @(negedge clk);
        settle(2);
    endtask

    task automatic expect_q(ref logic [20:0] q[$], input logic [20:0] exp, input string req, input string what);
        logic [20:0] got;
        got = (q.size() > 0) ? q.pop_front() : 21'h1FFFFF;
        chk(got == exp, req, what, got, exp);
    endtask

    initial begin
        rst = 1; live = 0; cfg_we = 0; cfg_we_n = 0; cfg_ch = 0; cfg_src = 0; cfg_dst = 0;
        cfg_src_io = 0; cfg_dst_io = 0; cfg_src_step = 0; cfg_dst_step = 0; cfg_word = 0;
        cfg_count = 0; cfg_tc_stop = 0; cfg_en = 0; dreq = 0; dreq_n = 0;
        rdy_man = 1; rnd_mode = 0; rdy_rnd = 1;
        done_hi[0] = 0; done_hi[1] = 0; rd_len = 0; rd_run = 0; nword_hi = 0;
        prev_rd = 0; prev_wr = 0; prev_nrd = 0;
        settle(3);
        rst = 0;
        @(negedge clk);
        live = 1;
        // R1 reset state
        chk(!bus_rd && !bus_wr && bus_addr == 0 && bus_wdata == 0, "R1", "bus after reset",
            {bus_rd, bus_wr, bus_addr}, 0);
        chk(chan_en == 0 && done == 0, "R1", "flags after reset", {chan_en, done}, 0);

        // R10: disabled channel with its request high
        load(0, 1, 20'h00400, 20'h00500, 0, 0, 2'b01, 2'b01, 0, 16'd1, 1, 0);
        dreq = 2'b10; settle(30);
        chk(rd_q.size() == 0 && wr_q.size() == 0, "R10", "disabled channel quiet", rd_q.size(), 0);
        dreq = 0;

        // S1: byte, src up in memory, dst down in I/O, count 2, random ready
        rnd_mode = 1;
        load(0, 0, 20'h00010, 20'h00200, 0, 1, 2'b01, 2'b10, 0, 16'd2, 1, 1);
        dreq = 2'b01; wait_off(0); dreq = 0;
        expect_q(rd_q, 21'h000010, "R6", "S1 read 1");
        expect_q(wr_q, 21'h100200, "R7", "S1 write 1");
        expect_q(rd_q, 21'h000011, "R6", "S1 read 2 (+1)");
        expect_q(wr_q, 21'h1001FF, "R6", "S1 write 2 (-1)");
        chk(chan_en[0] == 0, "R8", "S1 channel stopped", chan_en[0], 0);
        chk(done_hi[0] == 1, "R8", "S1 done one clock", done_hi[0], 1);

        // S2: word, src up across the top of the space, dst kept (code 11)
        load(0, 1, 20'hFFFFF, 20'h00300, 1, 0, 2'b01, 2'b11, 1, 16'd2, 1, 1);
        dreq = 2'b10; wait_off(1); dreq = 0;
        expect_q(rd_q, 21'h1FFFFF, "R6", "S2 read 1");
        expect_q(rd_q, 21'h100001, "R6", "S2 read 2 wraps (+2)");
        expect_q(wr_q, 21'h000300, "R6", "S2 write 1");
        expect_q(wr_q, 21'h000300, "R6", "S2 write 2 kept");

        // S3: both channels request in the same idle clock
        load(0, 0, 20'h01000, 20'h02000, 0, 0, 2'b00, 2'b00, 0, 16'd1, 1, 1);
        load(0, 1, 20'h03000, 20'h04000, 0, 0, 2'b00, 2'b00, 0, 16'd1, 1, 1);
        dreq = 2'b11; settle(40); wait_off(1); dreq = 0;
        expect_q(rd_q, 21'h001000, "R2", "S3 first read is channel 0");
        expect_q(wr_q, 21'h002000, "R3", "S3 channel 0 write");
        expect_q(rd_q, 21'h003000, "R3", "S3 then channel 1 read");
        expect_q(wr_q, 21'h004000, "R3", "S3 channel 1 write");
        chk(done_hi[0] == 2 && done_hi[1] == 2, "R8", "S3 done counts", {done_hi[0], done_hi[1]}, 2);

        // S4: ready held low for two wait clocks
        rnd_mode = 0; rdy_man = 1;
        load(0, 0, 20'h00050, 20'h00060, 0, 0, 2'b00, 2'b00, 0, 16'd1, 1, 1);
        dreq = 2'b01;
        for (int i = 0; i < 50 && !bus_rd; i++) @(negedge clk);
        rdy_man = 0; settle(3); rdy_man = 1;
        wait_off(0); dreq = 0;
        chk(rd_len == 4, "R4", "read strobe stretched by two waits", rd_len, 4);
        rd_q.delete(); wr_q.delete();

        // S5: terminate-on-count clear, count 1 wraps and the channel keeps running
        load(0, 0, 20'h00070, 20'h00080, 0, 0, 2'b01, 2'b01, 0, 16'd1, 0, 1);
        dreq = 2'b01; settle(25); dreq = 0; settle(12);
        chk(chan_en[0] == 1, "R8", "S5 channel still enabled", chan_en[0], 1);
        chk(done_hi[0] == 3, "R8", "S5 no done pulse", done_hi[0], 3);
        chk(rd_q.size() >= 2, "R8", "S5 kept transferring", rd_q.size(), 2);
        load(0, 0, 20'h0, 20'h0, 0, 0, 2'b00, 2'b00, 0, 16'd0, 0, 0);
        rd_q.delete(); wr_q.delete();

        // S6: narrow-bus instance ignores word setting
        load(1, 0, 20'h00100, 20'h00900, 0, 0, 2'b01, 2'b01, 1, 16'd2, 1, 1);
        dreq_n = 2'b01;
        for (int i = 0; i < 100 && n_en[0]; i++) @(negedge clk);
        dreq_n = 0; settle(2);
        expect_q(nrd_q, 21'h000100, "R9", "narrow read 1");
        expect_q(nrd_q, 21'h000101, "R9", "narrow read 2 steps by 1");
        chk(nword_hi == 0, "R9", "narrow bus_word low", nword_hi, 0);

        live = 0;
        if (!timed_out) begin
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule